// File: doc/BRIEF.md
# Power Shut-Off Sequencing Controller

This block lives in the always-on part of a chip and walks a switchable domain into power shut-off and back out. On its own clock it drives five controls toward that domain: a clock enable, an active-low isolation control, an active-low retention control, a power-switch control (high means the supply is cut) and an active-low domain reset. A `powered` status output is high only while the domain is fully up and usable.

The design also carries a behavioural model of the domain boundary so the handshake can be exercised in simulation. The model has one retained state register and two outputs that pass through isolation clamps. While the supply is cut, the register and the raw outputs read as unknown. Only the clamped outputs and the retention copy keep meaningful values.

The sequencer has nine named states. The two steady states are ON and OFF. The shut-off path is ON → CLKOFF → ISO → SAVE → OFF. The wake path is OFF → PWRUP → RESET → RESTORE → UNISO → ON. Each state lasts one clock, except the steady states, which wait for a request. A request that arrives mid-sequence is held in a pending flag. It is acted on once the controller reaches the steady state opposite to the one that request would produce, and it is dropped if the sequence ends in the state the request asks for.

Top module: `pso_seq_ctrl`

## Requirements
- R1: After reset the controller is in ON: clk_en=1, iso_n=1, ret_n=1, pwr_off=0, dom_rst_n=1, powered=1, and dom_state reads 0.
- R2: A sleep_req sampled in ON produces, on the next four clock edges, CLKOFF (clk_en=0), ISO (iso_n=0), SAVE (ret_n=0) and OFF (pwr_off=1). Each step takes one cycle, and powered is 0 from CLKOFF onward.
- R3: Whenever iso_n is 0, dom_out[0] is clamped to 0 and dom_out[1] is clamped to 1.
- R4: While iso_n stays 0, dom_out holds the same value on every clock edge and is never unknown.
- R5: While powered, dom_state loads dom_data on each clock edge with dom_load=1. dom_out[0] is the XOR of all dom_state bits and dom_out[1] is their OR. dom_load has no effect while clk_en is 0.
- R6: The falling edge of ret_n copies dom_state into retention storage. When ret_n rises again, dom_state takes back that copy, so after wake-up it equals the value held before shut-off.
- R7: A wake_req sampled in OFF produces, on the next five edges, PWRUP (pwr_off=0), RESET (dom_rst_n=0 for one cycle), RESTORE (ret_n=1), UNISO (iso_n=1) and ON (clk_en=1, powered=1).
- R8: A sleep_req that arrives during a wake sequence is held; ON lasts exactly one cycle and the shut-off sequence follows. A wake_req that arrives during shut-off is held in the same way; OFF lasts one cycle and the wake sequence follows.
- R9: wake_req while in ON and sleep_req while in OFF are ignored: the controls stay unchanged for the following cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock; all decisions on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of controller and model |
| sleep_req | input | 1 | Request to shut the domain off |
| wake_req | input | 1 | Request to power the domain back up |
| dom_load | input | 1 | Write strobe for the domain state register |
| dom_data | input | STATE_W | Value written into the domain state register |
| clk_en | output | 1 | Domain clock enable (0 = clock gated) |
| iso_n | output | 1 | Isolation control, active low |
| ret_n | output | 1 | Retention control, active low; falling edge saves, rising edge restores |
| pwr_off | output | 1 | Power switch control, 1 = supply cut |
| dom_rst_n | output | 1 | Domain reset, active low |
| powered | output | 1 | High only in the steady ON state |
| dom_state | output | STATE_W | Domain state register as seen at the boundary (unknown while off) |
| dom_out | output | 2 | Isolated domain outputs |

## Verification
The hardest situation to reach from the ports is a request that collides with a sequence already under way: a sleep request landing in the RESET step of a wake-up, or a wake request landing in CLKOFF. The stimulus places a one-cycle pulse of the opposite request at a counted edge inside each sequence. A scoreboard queue holds the full expected control trace, including the single-cycle stay in the steady state. The bench also keeps a write strobe asserted with inverted data through every gated step. This shows that only the retention path can change the restored register.

// File: rtl/pso_seq_pkg.sv
package pso_seq_pkg;

    typedef enum logic [3:0] {
        S_ON,
        S_CLKOFF,
        S_ISO,
        S_SAVE,
        S_OFF,
        S_PWRUP,
        S_RESET,
        S_RESTORE,
        S_UNISO
    } pso_state_e;

    typedef struct packed {
        logic clk_en;
        logic iso_n;
        logic ret_n;
        logic pwr_off;
        logic dom_rst_n;
        logic powered;
    } pso_ctrl_t;

    localparam int NUM_ISO_OUT = 2;

endpackage

// File: rtl/pso_seq_fsm.sv
module pso_seq_fsm
    import pso_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      wake_req,
    output pso_ctrl_t ctrl
);

    pso_state_e state_q, state_d;
    logic       sleep_pend_q, wake_pend_q;
    logic       go_sleep, go_wake;
    logic       steady;

    assign go_sleep = sleep_req | sleep_pend_q;
    assign go_wake  = wake_req  | wake_pend_q;
    assign steady   = (state_q == S_ON) || (state_q == S_OFF);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ON:      if (go_sleep) state_d = S_CLKOFF;
            S_CLKOFF:  state_d = S_ISO;
            S_ISO:     state_d = S_SAVE;
            S_SAVE:    state_d = S_OFF;
            S_OFF:     if (go_wake) state_d = S_PWRUP;
            S_PWRUP:   state_d = S_RESET;
            S_RESET:   state_d = S_RESTORE;
            S_RESTORE: state_d = S_UNISO;
            S_UNISO:   state_d = S_ON;
            default:   state_d = S_ON;
        endcase
    end

    // state register and held requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_ON;
            sleep_pend_q <= 1'b0;
            wake_pend_q  <= 1'b0;
        end else begin
            state_q      <= state_d;
            sleep_pend_q <= steady ? 1'b0 : (sleep_pend_q | sleep_req);
            wake_pend_q  <= steady ? 1'b0 : (wake_pend_q | wake_req);
        end
    end

    // control decode per state
    always_comb begin
        ctrl = '{clk_en: 1'b0, iso_n: 1'b0, ret_n: 1'b0,
                 pwr_off: 1'b0, dom_rst_n: 1'b1, powered: 1'b0};
        unique case (state_q)
            S_ON: begin
                ctrl.clk_en  = 1'b1;
                ctrl.iso_n   = 1'b1;
                ctrl.ret_n   = 1'b1;
                ctrl.powered = 1'b1;
            end
            S_CLKOFF: begin
                ctrl.iso_n = 1'b1;
                ctrl.ret_n = 1'b1;
            end
            S_ISO:     ctrl.ret_n = 1'b1;
            S_SAVE:    ctrl.ret_n = 1'b0;
            S_OFF:     ctrl.pwr_off = 1'b1;
            S_PWRUP:   ctrl.pwr_off = 1'b0;
            S_RESET:   ctrl.dom_rst_n = 1'b0;
            S_RESTORE: ctrl.ret_n = 1'b1;
            S_UNISO: begin
                ctrl.iso_n = 1'b1;
                ctrl.ret_n = 1'b1;
            end
            default: ctrl.powered = 1'b0;
        endcase
    end

    // shut-off ordering
    p_iso_after_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.iso_n) |-> !ctrl.clk_en && $past(!ctrl.clk_en));
    p_ret_after_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.ret_n) |-> !ctrl.iso_n && $past(!ctrl.iso_n));
    p_switch_after_ret_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.pwr_off) |-> !ctrl.ret_n && $past(!ctrl.ret_n));
    // wake ordering
    p_restore_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.ret_n) |-> $past(!ctrl.dom_rst_n) && !ctrl.pwr_off);
    p_uniso_after_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.iso_n) |-> ctrl.ret_n && $past(ctrl.ret_n));
    p_ungate_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.clk_en) |-> ctrl.iso_n && $past(ctrl.iso_n));
    // steady powered state has every control released
    p_powered_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.powered |-> ctrl.clk_en && ctrl.iso_n && ctrl.ret_n
                         && !ctrl.pwr_off && ctrl.dom_rst_n);

endmodule

// File: rtl/pso_domain_model.sv
module pso_domain_model #(
    parameter int STATE_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clk_en,
    input  logic                                 ret_n,
    input  logic                                 pwr_off,
    input  logic                                 dom_rst_n,
    input  logic                                 load,
    input  logic [STATE_W-1:0]                   data,
    output logic [STATE_W-1:0]                   state_q,
    output logic [pso_seq_pkg::NUM_ISO_OUT-1:0]  raw_out
);

    logic [STATE_W-1:0] keep_q;
    logic               ret_seen_q;
    logic               ret_fall, ret_rise;

    assign ret_fall = ret_seen_q & ~ret_n;
    assign ret_rise = ~ret_seen_q & ret_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_seen_q <= 1'b1;
            keep_q     <= '0;
        end else begin
            ret_seen_q <= ret_n;
            if (ret_fall) keep_q <= state_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (pwr_off) begin
            state_q <= 'x;
        end else if (!dom_rst_n) begin
            state_q <= '0;
        end else if (ret_rise) begin
            state_q <= keep_q;
        end else if (clk_en && load) begin
            state_q <= data;
        end
    end

    assign raw_out[0] = ^state_q;
    assign raw_out[1] = |state_q;

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ret_n) |=> keep_q == $past(state_q));
    p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_n) |=> state_q == $past(keep_q));
    p_gated_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && ret_n && dom_rst_n && !pwr_off && $past(ret_n)) |=> $stable(state_q));

endmodule

// File: rtl/pso_iso_bank.sv
module pso_iso_bank #(
    parameter int           NUM   = 2,
    parameter logic [NUM-1:0] CLAMP = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iso_n,
    input  logic [NUM-1:0] raw_in,
    output logic [NUM-1:0] iso_out
);

    for (genvar i = 0; i < NUM; i++) begin : g_cell
        assign iso_out[i] = iso_n ? raw_in[i] : CLAMP[i];

        p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !iso_n |-> iso_out[i] == CLAMP[i]);
        p_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!iso_n && $past(!iso_n)) |-> $stable(iso_out[i]));
        p_no_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !iso_n |-> !$isunknown(iso_out[i]));
    end

endmodule

// File: rtl/pso_seq_ctrl.sv
module pso_seq_ctrl
    import pso_seq_pkg::*;
#(
    parameter int                     STATE_W = 8,
    parameter logic [NUM_ISO_OUT-1:0] CLAMP   = 2'b10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_req,
    input  logic                   wake_req,
    input  logic                   dom_load,
    input  logic [STATE_W-1:0]     dom_data,
    output logic                   clk_en,
    output logic                   iso_n,
    output logic                   ret_n,
    output logic                   pwr_off,
    output logic                   dom_rst_n,
    output logic                   powered,
    output logic [STATE_W-1:0]     dom_state,
    output logic [NUM_ISO_OUT-1:0] dom_out
);

    pso_ctrl_t              ctrl;
    logic [NUM_ISO_OUT-1:0] raw;

    pso_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .ctrl      (ctrl)
    );

    pso_domain_model #(.STATE_W(STATE_W)) u_dom (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (ctrl.clk_en),
        .ret_n     (ctrl.ret_n),
        .pwr_off   (ctrl.pwr_off),
        .dom_rst_n (ctrl.dom_rst_n),
        .load      (dom_load),
        .data      (dom_data),
        .state_q   (dom_state),
        .raw_out   (raw)
    );

    pso_iso_bank #(.NUM(NUM_ISO_OUT), .CLAMP(CLAMP)) u_iso (
        .clk     (clk),
        .rst_n   (rst_n),
        .iso_n   (ctrl.iso_n),
        .raw_in  (raw),
        .iso_out (dom_out)
    );

    assign clk_en    = ctrl.clk_en;
    assign iso_n     = ctrl.iso_n;
    assign ret_n     = ctrl.ret_n;
    assign pwr_off   = ctrl.pwr_off;
    assign dom_rst_n = ctrl.dom_rst_n;
    assign powered   = ctrl.powered;

endmodule

// File: tb/pso_seq_ctrl_tb.sv
module pso_seq_ctrl_tb;

    localparam int W = 8;
    // control vector {clk_en, iso_n, ret_n, pwr_off, dom_rst_n, powered}
    localparam logic [5:0] V_ON      = 6'b111011;
    localparam logic [5:0] V_CLKOFF  = 6'b011010;
    localparam logic [5:0] V_ISO     = 6'b001010;
    localparam logic [5:0] V_SAVE    = 6'b000010;
    localparam logic [5:0] V_OFF     = 6'b000110;
    localparam logic [5:0] V_PWRUP   = 6'b000010;
    localparam logic [5:0] V_RESET   = 6'b000000;
    localparam logic [5:0] V_RESTORE = 6'b001010;
    localparam logic [5:0] V_UNISO   = 6'b011010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, dom_load = 1'b0;
    logic [W-1:0] dom_data = '0;
    logic clk_en, iso_n, ret_n, pwr_off, dom_rst_n, powered;
    logic [W-1:0] dom_state;
    logic [1:0]   dom_out;

    int n_run = 0, n_fail = 0;
    bit mon_en = 1'b0, done = 1'b0;
    logic [W-1:0] exp_state = '0;
    logic [5:0]   exp_q[$];
    string        tag_q[$];
    logic [1:0]   prev_out;
    bit           prev_iso = 1'b0;

    always #5 clk = ~clk;

    pso_seq_ctrl #(.STATE_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .dom_load(dom_load), .dom_data(dom_data), .clk_en(clk_en), .iso_n(iso_n),
        .ret_n(ret_n), .pwr_off(pwr_off), .dom_rst_n(dom_rst_n), .powered(powered),
        .dom_state(dom_state), .dom_out(dom_out)
    );

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(logic [5:0] v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // monitor: pops one expected control vector per cycle and checks the boundary
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en) begin
                logic [5:0] act;
                act = {clk_en, iso_n, ret_n, pwr_off, dom_rst_n, powered};
                if (exp_q.size() > 0) begin
                    logic [5:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(act === e, t, {10'd0, act}, {10'd0, e});
                end
                if (iso_n === 1'b0) begin
                    check(dom_out === 2'b10, "R3 clamp", {14'd0, dom_out}, 16'h2);
                    check(!$isunknown(dom_out), "R4 no-x", {14'd0, dom_out}, 16'h2);
                    if (prev_iso)
                        check(dom_out === prev_out, "R4 stable", {14'd0, dom_out}, {14'd0, prev_out});
                end
                if (powered === 1'b1) begin
                    check(dom_state === exp_state, "R5/R6 state", {8'd0, dom_state}, {8'd0, exp_state});
                    check(dom_out === {|exp_state, ^exp_state}, "R5 outputs",
                          {14'd0, dom_out}, {14'd0, |exp_state, ^exp_state});
                end
                prev_out = dom_out;
                prev_iso = (iso_n === 1'b0);
            end
        end
    end

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(logic [W-1:0] v);
        @(negedge clk);
        dom_load = 1'b1;
        dom_data = v;
        @(posedge clk);
        exp_state = v;
        @(negedge clk);
        dom_load = 1'b0;
    endtask

    // R2 shut-off, with a write strobe held through the gated steps (R5)
    task automatic do_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        push(V_CLKOFF, "R2 clkoff"); push(V_ISO, "R2 iso");
        push(V_SAVE, "R2 save");     push(V_OFF, "R2 off");
        @(negedge clk);
        sleep_req = 1'b0;
        dom_load = 1'b1;
        dom_data = ~exp_state;
        repeat (3) @(negedge clk);
        dom_load = 1'b0;
        drain();
    endtask

    // R7 wake-up, write strobe held through gated steps; state restored (R6)
    task automatic do_wake();
        @(negedge clk);
        wake_req = 1'b1;
        push(V_PWRUP, "R7 pwrup");     push(V_RESET, "R7 reset");
        push(V_RESTORE, "R7 restore"); push(V_UNISO, "R7 uniso");
        push(V_ON, "R7 on");
        @(negedge clk);
        wake_req = 1'b0;
        dom_load = 1'b1;
        dom_data = ~exp_state;
        repeat (4) @(negedge clk);
        dom_load = 1'b0;
        drain();
        check(dom_state === exp_state, "R6 restored", {8'd0, dom_state}, {8'd0, exp_state});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(V_ON, "R1 reset");
        mon_en = 1'b1;
        drain();
        check(dom_state === '0, "R1 state", {8'd0, dom_state}, 16'h0);

        for (int i = 0; i < 4; i++) begin
            do_load(W'($urandom));
            do_load(W'($urandom));
            do_sleep();
            if (i == 0) begin
                // R9: sleep while already off
                @(negedge clk);
                sleep_req = 1'b1;
                push(V_OFF, "R9 off-hold"); push(V_OFF, "R9 off-hold");
                @(negedge clk);
                sleep_req = 1'b0;
                drain();
            end
            do_wake();
        end

        // R9: wake while already on
        @(negedge clk);
        wake_req = 1'b1;
        push(V_ON, "R9 on-hold"); push(V_ON, "R9 on-hold"); push(V_ON, "R9 on-hold");
        @(negedge clk);
        wake_req = 1'b0;
        drain();

        // R8: wake request held during shut-off
        do_load(8'hA5);
        @(negedge clk);
        sleep_req = 1'b1;
        push(V_CLKOFF, "R8 clkoff"); push(V_ISO, "R8 iso"); push(V_SAVE, "R8 save");
        push(V_OFF, "R8 off-once"); push(V_PWRUP, "R8 pwrup"); push(V_RESET, "R8 reset");
        push(V_RESTORE, "R8 restore"); push(V_UNISO, "R8 uniso"); push(V_ON, "R8 on");
        @(negedge clk);
        sleep_req = 1'b0;
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        drain();
        check(dom_state === 8'hA5, "R8 restored", {8'd0, dom_state}, 16'h00A5);

        // R8: sleep request held during wake-up
        do_load(8'h3C);
        do_sleep();
        @(negedge clk);
        wake_req = 1'b1;
        push(V_PWRUP, "R8 pwrup"); push(V_RESET, "R8 reset"); push(V_RESTORE, "R8 restore");
        push(V_UNISO, "R8 uniso"); push(V_ON, "R8 on-once"); push(V_CLKOFF, "R8 clkoff");
        push(V_ISO, "R8 iso"); push(V_SAVE, "R8 save"); push(V_OFF, "R8 off");
        @(negedge clk);
        wake_req = 1'b0;
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        drain();
        do_wake();
        check(dom_state === 8'h3C, "R6 second save", {8'd0, dom_state}, 16'h003C);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule